// File: doc/BRIEF.md
# Interrupt Distributor Register File

This block is the shared front end of a small multiprocessor interrupt controller. It holds one configuration record per interrupt and turns interrupt lines and software requests into per-CPU pending requests. Each record has an enable, a trigger mode, a priority byte and a CPU routing byte. Software programs the records over a plain 32-bit word-addressed register bus. The downstream CPU interfaces receive one request bit for every (CPU, interrupt) pair and acknowledge edge-latched requests through a per-CPU acknowledge strobe with an interrupt ID.

IDs 0 to 15 are software-generated and come only from writes to a software-request register. IDs 16 and above have hardware lines (`irq_src`). IDs 0 to 31 are private to each CPU: every CPU has its own copy of their enable bits, selected by the `bus_cpu` input that names the issuing CPU, and they ignore the routing byte. IDs 32 and above are shared. They have one enable bit, and routing byte bit k steers them to CPU k. The request outputs are combinational from the stored state and the level inputs.

Word address map (10-bit word address). Control is at 0x000 and the type register at 0x001. The software-request register is at 0x002 and reads as zero. The enable-set words are at 0x040+w and the enable-clear words at 0x060+w. The priority words are at 0x100+w, the routing words at 0x200+w and the trigger words at 0x300+w.

Top module: `irq_distributor`

## Requirements
- R1: Writing 1 to bit b of enable-set word w (0x040+w) enables ID 32*w+b. Writing 1 to the same bit of enable-clear word w (0x060+w) disables it. Zero bits change nothing. Both words read back the current enable state.
- R2: The enables of IDs 0 to 31 (word 0) are banked per CPU: reads and writes reach the copy of the CPU given on `bus_cpu`, and another CPU's copy is unaffected.
- R3: Trigger word w (0x300+w) holds a 2-bit field for ID 16*w+j at bits 2j+1:2j. Bit 2j+1 = 1 selects rising-edge, 0 selects level, and bit 2j always reads 0. The fields of IDs 0 to 15 are fixed at 2'b10 and ignore writes.
- R4: The priority byte (0x100+w) and the routing byte (0x200+w) of ID n sit in byte lane n mod 4 of word n/4 and read back as written.
- R5: The type register (0x001) reads (NUM_IRQ/32)-1 in bits 4:0 and zero elsewhere.
- R6: Control bit 0 (0x000) gates forwarding. While it is 0, every `cpu_req` bit is 0.
- R7: A write of the software-request register with target bits 23:16 (bit 16+k = CPU k) and ID in bits 3:0 makes that ID pending on each targeted CPU until that CPU acknowledges it.
- R8: A level-configured ID requests while its input is high and stops when the input falls, with no acknowledge needed.
- R9: An edge-configured ID latches pending on a 0-to-1 input transition, independently per CPU. An acknowledge (`ack_vld[k]` with ID on `ack_id[k]`) clears only CPU k's copy.
- R10: A shared ID reaches CPU k only when bit k of its routing byte is set. Request bit for CPU k, ID n is `cpu_req[k*NUM_IRQ+n]`.
- R11: Unimplemented words read 0 and ignore writes. Examples are address 0x003, enable words beyond NUM_IRQ/32 and priority words beyond NUM_IRQ/4.
- R12: After reset all enables, routing, priority, trigger bits (level), pending latches and the control bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cpu | input | $clog2(NUM_CPU) | CPU issuing the bus access (selects banked enables) |
| wr_en | input | 1 | Write strobe for the current word |
| addr | input | 10 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_src | input | NUM_IRQ-16 | Hardware interrupt lines for IDs 16..NUM_IRQ-1 |
| ack_vld | input | NUM_CPU | Per-CPU acknowledge strobe |
| ack_id | input | NUM_CPU*$clog2(NUM_IRQ) | Per-CPU acknowledged ID |
| cpu_req | output | NUM_CPU*NUM_IRQ | Forwarded request per CPU and ID |

## Verification
The hardest situation to reach is an edge latch that is set for two CPUs and then must survive an acknowledge from one while the other still holds it. The stimulus routes one edge ID to both CPUs and pulses its line for a single cycle. It then acknowledges from CPU 0 alone and checks that only CPU 0's request drops before acknowledging CPU 1. Banked enables are exercised by issuing the same enable word from each CPU and reading it back from the other. A software request targeted at one CPU only checks that the other stays idle.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
    localparam int        ADDR_W     = 10;
    localparam logic [1:0] RG_MISC   = 2'd0;
    localparam logic [1:0] RG_PRIO   = 2'd1;
    localparam logic [1:0] RG_TGT    = 2'd2;
    localparam logic [1:0] RG_CFG    = 2'd3;
    localparam logic [7:0] REG_CTRL  = 8'h00;
    localparam logic [7:0] REG_TYPE  = 8'h01;
    localparam logic [7:0] REG_SOFT  = 8'h02;
    localparam logic [7:0] ENSET_BASE = 8'h40;
    localparam logic [7:0] ENCLR_BASE = 8'h60;
endpackage

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
    import irq_dist_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2,
    localparam int CPU_W = $clog2(NUM_CPU),
    localparam int NSH   = NUM_IRQ - 32,
    localparam int NCF   = NUM_IRQ - 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CPU_W-1:0]           bus_cpu,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [31:0]                wdata,
    output logic [31:0]                rdata,
    output logic                       ctrl_en,
    output logic [NUM_CPU*NUM_IRQ-1:0] en_vec,
    output logic [NUM_CPU*NUM_IRQ-1:0] route_vec,
    output logic [NCF-1:0]             edge_cfg,
    output logic                       sgi_vld,
    output logic [NUM_CPU-1:0]         sgi_tgt,
    output logic [3:0]                 sgi_id
);
    typedef struct packed {
        logic                         ctrl;
        logic [NUM_CPU-1:0][31:0]     en_bank;
        logic [NSH-1:0]               en_shr;
        logic [NCF-1:0]               cfg;
        logic [NUM_IRQ-1:0][7:0]      prio;
        logic [NUM_IRQ-1:0][7:0]      tgt;
    } regs_t;

    regs_t r_d, r_q;
    logic [1:0] rg;
    logic [7:0] idx;

    assign rg  = addr[9:8];
    assign idx = addr[7:0];

    // next-state computation
    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (rg)
                RG_MISC: begin
                    if (idx == REG_CTRL) r_d.ctrl = wdata[0];
                    for (int b = 0; b < 32; b++) begin
                        if (wdata[b] && idx == ENSET_BASE) r_d.en_bank[bus_cpu][b] = 1'b1;
                        if (wdata[b] && idx == ENCLR_BASE) r_d.en_bank[bus_cpu][b] = 1'b0;
                    end
                    for (int s = 0; s < NSH; s++) begin
                        if (wdata[s % 32] && idx == ENSET_BASE + 8'((s + 32) / 32)) r_d.en_shr[s] = 1'b1;
                        if (wdata[s % 32] && idx == ENCLR_BASE + 8'((s + 32) / 32)) r_d.en_shr[s] = 1'b0;
                    end
                end
                RG_PRIO: begin
                    for (int n = 0; n < NUM_IRQ; n++)
                        if (idx == 8'(n / 4)) r_d.prio[n] = wdata[8*(n%4) +: 8];
                end
                RG_TGT: begin
                    for (int n = 0; n < NUM_IRQ; n++)
                        if (idx == 8'(n / 4)) r_d.tgt[n] = wdata[8*(n%4) +: 8];
                end
                default: begin
                    for (int s = 0; s < NCF; s++)
                        if (idx == 8'((s + 16) / 16)) r_d.cfg[s] = wdata[2*((s + 16) % 16) + 1];
                end
            endcase
        end
    end

    // read mux
    always_comb begin
        rdata = '0;
        unique case (rg)
            RG_MISC: begin
                if (idx == REG_CTRL) rdata[0] = r_q.ctrl;
                if (idx == REG_TYPE) rdata[4:0] = 5'(NUM_IRQ / 32 - 1);
                if (idx == ENSET_BASE || idx == ENCLR_BASE) rdata = r_q.en_bank[bus_cpu];
                for (int s = 0; s < NSH; s++)
                    if (idx == ENSET_BASE + 8'((s + 32) / 32) || idx == ENCLR_BASE + 8'((s + 32) / 32))
                        rdata[s % 32] = r_q.en_shr[s];
            end
            RG_PRIO: begin
                for (int n = 0; n < NUM_IRQ; n++)
                    if (idx == 8'(n / 4)) rdata[8*(n%4) +: 8] = r_q.prio[n];
            end
            RG_TGT: begin
                for (int n = 0; n < NUM_IRQ; n++)
                    if (idx == 8'(n / 4)) rdata[8*(n%4) +: 8] = r_q.tgt[n];
            end
            default: begin
                if (idx == 8'h00)
                    for (int j = 0; j < 16; j++) rdata[2*j+1] = 1'b1;
                for (int s = 0; s < NCF; s++)
                    if (idx == 8'((s + 16) / 16)) rdata[2*((s + 16) % 16) + 1] = r_q.cfg[s];
            end
        endcase
    end

    // derived views for the pending and routing stages
    always_comb begin
        for (int k = 0; k < NUM_CPU; k++) begin
            for (int b = 0; b < 32; b++) begin
                en_vec[k*NUM_IRQ + b]    = r_q.en_bank[k][b];
                route_vec[k*NUM_IRQ + b] = 1'b1;
            end
            for (int s = 0; s < NSH; s++) begin
                en_vec[k*NUM_IRQ + 32 + s]    = r_q.en_shr[s];
                route_vec[k*NUM_IRQ + 32 + s] = r_q.tgt[s + 32][k];
            end
        end
    end

    assign ctrl_en  = r_q.ctrl;
    assign edge_cfg = r_q.cfg;
    assign sgi_vld  = wr_en && (rg == RG_MISC) && (idx == REG_SOFT);
    assign sgi_tgt  = wdata[16 +: NUM_CPU];
    assign sgi_id   = wdata[3:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/irq_dist_pend.sv
module irq_dist_pend #(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2,
    localparam int IDW = $clog2(NUM_IRQ),
    localparam int NCF = NUM_IRQ - 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_IRQ-1:16]        irq_src,
    input  logic [NCF-1:0]             edge_cfg,
    input  logic                       sgi_vld,
    input  logic [NUM_CPU-1:0]         sgi_tgt,
    input  logic [3:0]                 sgi_id,
    input  logic [NUM_CPU-1:0]         ack_vld,
    input  logic [NUM_CPU*IDW-1:0]     ack_id,
    output logic [NUM_CPU*NUM_IRQ-1:0] raw_pend
);
    typedef struct packed {
        logic [NUM_CPU-1:0][NUM_IRQ-1:0] latch;
        logic [NCF-1:0]                  prev;
    } pend_t;

    pend_t s_d, s_q;

    always_comb begin
        logic hit;
        s_d      = s_q;
        s_d.prev = irq_src;
        for (int k = 0; k < NUM_CPU; k++) begin
            for (int n = 0; n < 16; n++) begin
                hit = ack_vld[k] && (ack_id[k*IDW +: IDW] == IDW'(n));
                s_d.latch[k][n] = (s_q.latch[k][n] && !hit)
                                || (sgi_vld && sgi_tgt[k] && sgi_id == 4'(n));
            end
            for (int s = 0; s < NCF; s++) begin
                hit = ack_vld[k] && (ack_id[k*IDW +: IDW] == IDW'(s + 16));
                s_d.latch[k][s+16] = edge_cfg[s]
                    && ((s_q.latch[k][s+16] && !hit) || (irq_src[s+16] && !s_q.prev[s]));
            end
        end
    end

    always_comb begin
        for (int k = 0; k < NUM_CPU; k++) begin
            for (int n = 0; n < 16; n++)
                raw_pend[k*NUM_IRQ + n] = s_q.latch[k][n];
            for (int s = 0; s < NCF; s++)
                raw_pend[k*NUM_IRQ + s + 16] = edge_cfg[s] ? s_q.latch[k][s+16] : irq_src[s+16];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/irq_dist_route.sv
module irq_dist_route #(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2
) (
    input  logic                       ctrl_en,
    input  logic [NUM_CPU*NUM_IRQ-1:0] raw_pend,
    input  logic [NUM_CPU*NUM_IRQ-1:0] en_vec,
    input  logic [NUM_CPU*NUM_IRQ-1:0] route_vec,
    output logic [NUM_CPU*NUM_IRQ-1:0] cpu_req
);
    for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
        assign cpu_req[k*NUM_IRQ +: NUM_IRQ] = ctrl_en
            ? (raw_pend[k*NUM_IRQ +: NUM_IRQ] & en_vec[k*NUM_IRQ +: NUM_IRQ]
               & route_vec[k*NUM_IRQ +: NUM_IRQ])
            : '0;
    end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irq_dist_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2,
    localparam int IDW   = $clog2(NUM_IRQ),
    localparam int CPU_W = $clog2(NUM_CPU)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CPU_W-1:0]           bus_cpu,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [31:0]                wdata,
    output logic [31:0]                rdata,
    input  logic [NUM_IRQ-1:16]        irq_src,
    input  logic [NUM_CPU-1:0]         ack_vld,
    input  logic [NUM_CPU*IDW-1:0]     ack_id,
    output logic [NUM_CPU*NUM_IRQ-1:0] cpu_req
);
    logic                       ctrl_en;
    logic [NUM_CPU*NUM_IRQ-1:0] en_vec;
    logic [NUM_CPU*NUM_IRQ-1:0] route_vec;
    logic [NUM_CPU*NUM_IRQ-1:0] raw_pend;
    logic [NUM_IRQ-17:0]        edge_cfg;
    logic                       sgi_vld;
    logic [NUM_CPU-1:0]         sgi_tgt;
    logic [3:0]                 sgi_id;

    irq_dist_regs #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ctrl_en(ctrl_en),
        .en_vec(en_vec), .route_vec(route_vec), .edge_cfg(edge_cfg),
        .sgi_vld(sgi_vld), .sgi_tgt(sgi_tgt), .sgi_id(sgi_id)
    );

    irq_dist_pend #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_pend (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .edge_cfg(edge_cfg),
        .sgi_vld(sgi_vld), .sgi_tgt(sgi_tgt), .sgi_id(sgi_id),
        .ack_vld(ack_vld), .ack_id(ack_id), .raw_pend(raw_pend)
    );

    irq_dist_route #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_route (
        .ctrl_en(ctrl_en), .raw_pend(raw_pend), .en_vec(en_vec),
        .route_vec(route_vec), .cpu_req(cpu_req)
    );
endmodule

// File: rtl/irq_distributor_chk.sv
module irq_distributor_chk #(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2,
    localparam int IDW = $clog2(NUM_IRQ)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [9:0]                 addr,
    input logic [31:0]                wdata,
    input logic [31:0]                rdata,
    input logic [NUM_CPU*NUM_IRQ-1:0] raw_pend,
    input logic [NUM_IRQ-17:0]        edge_cfg,
    input logic                       sgi_vld,
    input logic [NUM_CPU-1:0]         sgi_tgt,
    input logic [3:0]                 sgi_id,
    input logic [NUM_CPU-1:0]         ack_vld,
    input logic [NUM_CPU*IDW-1:0]     ack_id,
    input logic [NUM_CPU*NUM_IRQ-1:0] cpu_req
);
    p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 10'h000 && !wdata[0]) |=> (cpu_req == '0));

    p_sgi_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sgi_vld && sgi_tgt[0]) |=> raw_pend[$past(sgi_id)]);

    p_type_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 10'h001) |-> (rdata == 32'(NUM_IRQ / 32 - 1)));

    p_unimpl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 10'h003) |-> (rdata == '0));

    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 10'h061 && wdata[0]) |=> (!cpu_req[32] && !cpu_req[NUM_IRQ + 32]));

    for (genvar s = 0; s < NUM_IRQ - 16; s++) begin : g_hold
        p_edge_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_cfg[s] && raw_pend[s+16] && !(wr_en && addr[9:8] == 2'b11)
             && !(ack_vld[0] && ack_id[IDW-1:0] == IDW'(s + 16)))
            |=> raw_pend[s+16]);
    end
endmodule

bind irq_distributor irq_distributor_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .raw_pend(raw_pend), .edge_cfg(edge_cfg),
    .sgi_vld(sgi_vld), .sgi_tgt(sgi_tgt), .sgi_id(sgi_id),
    .ack_vld(ack_vld), .ack_id(ack_id), .cpu_req(cpu_req)
);

// File: tb/sim_irq_distributor.sv
`timescale 1ns/1ps
module sim_irq_distributor;
    localparam int N = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [0:0]   bus_cpu = '0;
    logic         wr_en = 1'b0;
    logic [9:0]   addr = 10'h3FF;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [N-1:16] irq_src = '0;
    logic [1:0]   ack_vld = '0;
    logic [11:0]  ack_id = '0;
    logic [2*N-1:0] cpu_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_distributor #(.NUM_IRQ(N), .NUM_CPU(2)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_src(irq_src),
        .ack_vld(ack_vld), .ack_id(ack_id), .cpu_req(cpu_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic c, input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_cpu = c; addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = 10'h3FF;
        #1;
    endtask

    task automatic rd(input logic c, input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_cpu = c; addr = a;
        #1 d = rdata;
    endtask

    task automatic ack(input int c, input int id);
        @(negedge clk);
        ack_vld[c] = 1'b1; ack_id[c*6 +: 6] = 6'(id);
        @(negedge clk);
        ack_vld = '0;
        #1;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R12 cpu_req after reset", 32'(cpu_req != '0), 32'd0);
        rd(0, 10'h000, v); check("R12 control", v, 32'd0);
        rd(0, 10'h041, v); check("R12 shared enables", v, 32'd0);
        rd(1, 10'h040, v); check("R12 banked enables", v, 32'd0);
        rd(0, 10'h302, v); check("R12 trigger word", v, 32'd0);
        rd(0, 10'h20A, v); check("R12 routing word", v, 32'd0);
    endtask

    task automatic t_type;
        logic [31:0] v;
        rd(0, 10'h001, v); check("R5 type register", v, 32'd1);
    endtask

    task automatic t_enable;
        logic [31:0] v;
        wr(0, 10'h041, 32'h5);
        rd(0, 10'h041, v); check("R1 set word readback", v, 32'h5);
        rd(0, 10'h061, v); check("R1 clear word readback", v, 32'h5);
        wr(0, 10'h061, 32'h4);
        rd(0, 10'h041, v); check("R1 clear bit", v, 32'h1);
        wr(0, 10'h041, 32'h0);
        wr(0, 10'h061, 32'h0);
        rd(0, 10'h041, v); check("R1 zero writes no effect", v, 32'h1);
    endtask

    task automatic t_bank;
        logic [31:0] v;
        wr(0, 10'h040, 32'h0001_0000);
        rd(1, 10'h040, v); check("R2 other bank untouched", v, 32'h0);
        rd(0, 10'h060, v); check("R2 own bank", v, 32'h0001_0000);
        wr(1, 10'h060, 32'h0001_0000);
        rd(0, 10'h040, v); check("R2 clear on other bank", v, 32'h0001_0000);
    endtask

    task automatic t_cfg;
        logic [31:0] v;
        wr(0, 10'h300, 32'h0);
        rd(0, 10'h300, v); check("R3 fixed soft fields", v, 32'hAAAA_AAAA);
        wr(0, 10'h301, 32'hFFFF_FFFF);
        rd(0, 10'h301, v); check("R3 edge bits only", v, 32'hAAAA_AAAA);
        wr(0, 10'h301, 32'h0);
        rd(0, 10'h301, v); check("R3 back to level", v, 32'h0);
    endtask

    task automatic t_bytes;
        logic [31:0] v;
        wr(0, 10'h109, 32'h1122_3344);
        rd(0, 10'h109, v); check("R4 priority lanes", v, 32'h1122_3344);
        rd(0, 10'h108, v); check("R4 neighbour priority word", v, 32'h0);
        wr(0, 10'h20B, 32'hA5C3_0F81);
        rd(0, 10'h20B, v); check("R4 routing lanes", v, 32'hA5C3_0F81);
    endtask

    task automatic t_unimpl;
        logic [31:0] v;
        rd(0, 10'h003, v); check("R11 hole read", v, 32'h0);
        wr(0, 10'h110, 32'hFFFF_FFFF);
        rd(0, 10'h110, v); check("R11 priority beyond range", v, 32'h0);
        wr(0, 10'h042, 32'hFFFF_FFFF);
        rd(0, 10'h042, v); check("R11 enable beyond range", v, 32'h0);
        rd(0, 10'h041, v); check("R11 implemented word intact", v, 32'h1);
    endtask

    task automatic t_level;
        wr(0, 10'h000, 32'h1);
        wr(0, 10'h041, 32'h100);
        wr(0, 10'h20A, 32'h0000_0002);
        @(negedge clk); irq_src[40] = 1'b1; #1;
        check("R8 level request cpu1", 32'(cpu_req[N+40]), 32'd1);
        check("R10 not routed to cpu0", 32'(cpu_req[40]), 32'd0);
        wr(0, 10'h000, 32'h0);
        check("R6 gate off", 32'(cpu_req != '0), 32'd0);
        wr(0, 10'h000, 32'h1);
        check("R6 gate on again", 32'(cpu_req[N+40]), 32'd1);
        @(negedge clk); irq_src[40] = 1'b0; #1;
        check("R8 level drops with input", 32'(cpu_req[N+40]), 32'd0);
    endtask

    task automatic t_edge;
        wr(0, 10'h302, 32'h0008_0000);
        wr(0, 10'h041, 32'h200);
        wr(0, 10'h20A, 32'h0000_0302);
        @(negedge clk); irq_src[41] = 1'b1;
        @(negedge clk); irq_src[41] = 1'b0; #1;
        check("R9 edge latched cpu0", 32'(cpu_req[41]), 32'd1);
        check("R9 edge latched cpu1", 32'(cpu_req[N+41]), 32'd1);
        repeat (3) @(negedge clk);
        #1 check("R9 held without ack", 32'(cpu_req[41]), 32'd1);
        ack(0, 41);
        check("R9 cpu0 ack clears cpu0", 32'(cpu_req[41]), 32'd0);
        check("R9 cpu1 copy held", 32'(cpu_req[N+41]), 32'd1);
        ack(1, 41);
        check("R9 cpu1 ack clears", 32'(cpu_req[N+41]), 32'd0);
    endtask

    task automatic t_sgi;
        wr(0, 10'h040, 32'h8);
        wr(1, 10'h040, 32'h8);
        wr(0, 10'h002, 32'h0002_0003);
        check("R7 soft pending cpu1", 32'(cpu_req[N+3]), 32'd1);
        check("R7 untargeted cpu0 idle", 32'(cpu_req[3]), 32'd0);
        ack(1, 3);
        check("R7 ack clears soft", 32'(cpu_req[N+3]), 32'd0);
        wr(1, 10'h002, 32'h0003_0003);
        check("R7 both targeted cpu0", 32'(cpu_req[3]), 32'd1);
        check("R7 both targeted cpu1", 32'(cpu_req[N+3]), 32'd1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_type();
        t_enable();
        t_bank();
        t_cfg();
        t_bytes();
        t_unimpl();
        t_level();
        t_edge();
        t_sgi();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule